// File: doc/BRIEF.md
# Pass-Window Best-Tap Selector

This block picks a sampling tap from the result of a delay sweep. A 64-bit pass map holds one bit per delay tap, and a set bit means that tap passed. After a start pulse the block walks the map from tap 0 upward. It evaluates one start position per clock cycle and measures the run of consecutive passing taps that begins there. It keeps the longest run. At the end it reports a chosen tap inside that run, together with the run length.

The chosen tap depends on where the winning run starts. A run anchored at tap 0 is sampled one third of the way in. Any other run is sampled at its midpoint. An all-zero map is reported as an error. When the upper half of the map is empty, the scan can stop early: it stops once a wide enough window close to tap 0 has been found, which suits sweeps that cover only the lower half of the taps. A single-cycle done pulse marks the end of every search, and the results hold until the next search completes.

Top module: `tap_window_sel`

## Requirements
- R1: After reset, busy_o, done_o, err_o, tap_o and maxlen_o are all zero.
- R2: An all-zero map gives a done pulse on the cycle after start, with err_o=1, tap_o=0, maxlen_o=0 and no busy cycles.
- R3: maxlen_o is the length of the longest run of consecutive ones in the map. A run ends at bit 63 and does not continue into bit 0.
- R4: When several runs have the same greatest length, the one with the lowest start position is reported.
- R5: If the winning run starts at bit 0, tap_o = floor(len/3). A full map of 64 ones gives tap 21.
- R6: If the winning run starts at bit s>0, tap_o = s + floor(len/2), taken modulo 64.
- R7: When map bits 63..32 are all zero, the scan stops as soon as a run of at least 12 has been measured and the best start so far is below 4. The result then reflects the best run at that point, even if a longer run lies further up. Bits 63..32 being nonzero, or the best start being 4 or more, prevents the early stop.
- R8: busy_o is high for exactly one cycle per start position evaluated. The position advances by the measured run length, or by 1 when that length is zero. done_o is a one-cycle pulse in the cycle after the last busy cycle, and busy_o and done_o are never high together.
- R9: A start pulse while busy_o is high is ignored, and the search in progress finishes with its own result.
- R10: tap_o, maxlen_o and err_o change only in a cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a search on the map presented in the same cycle |
| map_i | input | 64 | Pass map, bit i set when tap i passed |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| tap_o | output | 6 | Chosen sampling tap |
| maxlen_o | output | 7 | Length of the longest passing run |
| err_o | output | 1 | No tap passed |

## Verification
The hardest behaviour to reach from the ports is the early stop. It only shows when the lower half of the map holds a window of at least 12 starting below tap 4 and a longer window further up, so that stopping early gives a different answer than a full scan. The stimulus builds such lower-half maps. It then repeats one of them with bit 63 set, and builds another whose first wide window starts at tap 4. In both of those cases the early stop must not happen, and the busy-cycle count confirms how far each scan ran.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/tap_run_len.sv
// Length of the run of ones starting at position pos; the run ends at the top bit.
module tap_run_len #(
  parameter int MAP_W = 64,
  localparam int POS_W = $clog2(MAP_W),
  localparam int LEN_W = POS_W + 1
) (
  input  logic [MAP_W-1:0] map_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [LEN_W-1:0] len_o
);
  logic [MAP_W-1:0] shifted;
  logic             hit;

  always_comb begin
    shifted = map_i >> pos_i;
    len_o   = LEN_W'(MAP_W);
    hit     = 1'b0;
    for (int i = 0; i < MAP_W; i++) begin
      if (!hit && !shifted[i]) begin
        len_o = LEN_W'(i);
        hit   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tap_pick.sv
// Sampling point inside a window: one third in when anchored at 0, else midpoint.
module tap_pick #(
  parameter int MAP_W = 64,
  localparam int POS_W = $clog2(MAP_W),
  localparam int LEN_W = POS_W + 1
) (
  input  logic [POS_W-1:0] start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [POS_W-1:0] tap_o
);
  logic [LEN_W-1:0] offs;
  logic [LEN_W-1:0] sum;

  always_comb begin
    if (start_i == '0) offs = len_i / LEN_W'(3);
    else               offs = len_i >> 1;
    sum   = {1'b0, start_i} + offs;
    tap_o = sum[POS_W-1:0];
  end
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel
  import tap_sel_pkg::*;
#(
  parameter int MAP_W           = 64,
  parameter int EARLY_SPAN      = 32,
  parameter int EARLY_MIN_LEN   = 12,
  parameter int EARLY_START_LIM = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [MAP_W-1:0]           map_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [$clog2(MAP_W)-1:0]   tap_o,
  output logic [$clog2(MAP_W):0]     maxlen_o,
  output logic                       err_o
);
  localparam int POS_W = $clog2(MAP_W);
  localparam int LEN_W = POS_W + 1;
  localparam logic [LEN_W-1:0] END_POS   = LEN_W'(MAP_W);
  localparam logic [LEN_W-1:0] MIN_LEN_L = LEN_W'(EARLY_MIN_LEN);
  localparam logic [POS_W-1:0] START_LIM = POS_W'(EARLY_START_LIM);

  // reset synchronizer: asserts asynchronously, releases on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  scan_state_e      state_q, state_d;
  logic [MAP_W-1:0] map_q, map_d;
  logic [LEN_W-1:0] pos_q, pos_d;
  logic [POS_W-1:0] bstart_q, bstart_d;
  logic [LEN_W-1:0] blen_q, blen_d;
  logic [POS_W-1:0] tap_q, tap_d;
  logic [LEN_W-1:0] maxlen_q, maxlen_d;
  logic             err_q, err_d;
  logic             done_q, done_d;
  logic             res_en;

  logic [LEN_W-1:0] run_len;
  logic             is_better;
  logic [POS_W-1:0] cand_start;
  logic [LEN_W-1:0] cand_len;
  logic [LEN_W-1:0] step, pos_adv;
  logic             upper_clear, early_hit, finish;
  logic [POS_W-1:0] pick_tap;

  tap_run_len #(.MAP_W(MAP_W)) u_run (
    .map_i (map_q),
    .pos_i (pos_q[POS_W-1:0]),
    .len_o (run_len)
  );

  tap_pick #(.MAP_W(MAP_W)) u_pick (
    .start_i (cand_start),
    .len_i   (cand_len),
    .tap_o   (pick_tap)
  );

  always_comb begin
    is_better   = run_len > blen_q;
    cand_start  = is_better ? pos_q[POS_W-1:0] : bstart_q;
    cand_len    = is_better ? run_len : blen_q;
    step        = (run_len == '0) ? LEN_W'(1) : run_len;
    pos_adv     = pos_q + step;
    upper_clear = ~|map_q[MAP_W-1:EARLY_SPAN];
    early_hit   = upper_clear && (run_len >= MIN_LEN_L) && (cand_start < START_LIM);
    finish      = (pos_adv >= END_POS) || early_hit;
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    map_d    = map_q;
    pos_d    = pos_q;
    bstart_d = bstart_q;
    blen_d   = blen_q;
    tap_d    = tap_q;
    maxlen_d = maxlen_q;
    err_d    = err_q;
    done_d   = 1'b0;
    res_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          map_d    = map_i;
          pos_d    = '0;
          bstart_d = '0;
          blen_d   = '0;
          if (map_i == '0) begin
            res_en   = 1'b1;
            tap_d    = '0;
            maxlen_d = '0;
            err_d    = 1'b1;
            done_d   = 1'b1;
          end else begin
            state_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        pos_d    = pos_adv;
        bstart_d = cand_start;
        blen_d   = cand_len;
        if (finish) begin
          state_d  = ST_IDLE;
          res_en   = 1'b1;
          tap_d    = pick_tap;
          maxlen_d = cand_len;
          err_d    = 1'b0;
          done_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control and scan registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      map_q    <= '0;
      pos_q    <= '0;
      bstart_q <= '0;
      blen_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      map_q    <= map_d;
      pos_q    <= pos_d;
      bstart_q <= bstart_d;
      blen_q   <= blen_d;
      done_q   <= done_d;
    end
  end

  // result registers, written only on completion
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tap_q    <= '0;
      maxlen_q <= '0;
      err_q    <= 1'b0;
    end else if (res_en) begin
      tap_q    <= tap_d;
      maxlen_q <= maxlen_d;
      err_q    <= err_d;
    end
  end

  assign busy_o   = (state_q == ST_SCAN);
  assign done_o   = done_q;
  assign tap_o    = tap_q;
  assign maxlen_o = maxlen_q;
  assign err_o    = err_q;

  // R8: busy and done are exclusive, done lasts one cycle
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy_o && done_o));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  // R8: the scan position stays inside the map while busy
  p_pos_bound_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> (pos_q < END_POS));
  // R3: a measured run never extends past the top bit
  p_run_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> (({1'b0, pos_q} + {1'b0, run_len}) <= {1'b0, END_POS}));
  // R2: error results carry zero tap and length
  p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && err_o) |-> (tap_o == '0 && maxlen_o == '0));
  // R3: a successful result has a nonempty window containing the tap
  p_ok_len_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !err_o) |-> (maxlen_o != '0));
  // R10: results hold outside the done cycle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_o |-> ($stable(tap_o) && $stable(maxlen_o) && $stable(err_o)));
  // R9: the latched map does not change during a scan
  p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && $past(busy_o)) |-> $stable(map_q));
endmodule

// File: tb/tap_window_sel_test.sv
module tap_window_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] map_i = '0;
  logic        busy_o, done_o, err_o;
  logic [5:0]  tap_o;
  logic [6:0]  maxlen_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  tap_window_sel uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .map_i(map_i),
    .busy_o(busy_o), .done_o(done_o), .tap_o(tap_o),
    .maxlen_o(maxlen_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one search and count busy cycles until done (sampled at negedge)
  task automatic launch(input logic [63:0] m, output int busy_cnt, output bit timed_out);
    int cyc = 0;
    busy_cnt  = 0;
    timed_out = 0;
    @(negedge clk);
    start_i = 1'b1;
    map_i   = m;
    @(negedge clk);
    start_i = 1'b0;
    map_i   = '0;
    while (!done_o && cyc < 500) begin
      if (busy_o) busy_cnt++;
      @(negedge clk);
      cyc++;
    end
    timed_out = !done_o;
  endtask

  task automatic run_case(input string req, input logic [63:0] m, input int exp_tap,
                          input int exp_len, input bit exp_err, input int exp_busy);
    int  bc;
    bit  to;
    launch(m, bc, to);
    chk(!to, req, "done seen", to, 0);
    chk(err_o == exp_err, req, "err", err_o, exp_err);
    chk(tap_o == 6'(exp_tap), req, "tap", tap_o, exp_tap);
    chk(maxlen_o == 7'(exp_len), req, "maxlen", maxlen_o, exp_len);
    if (exp_busy >= 0) chk(bc == exp_busy, req, "busy cycles", bc, exp_busy);
    @(negedge clk);
    chk(!done_o, "R8", "done one cycle", done_o, 0);
    chk(tap_o == 6'(exp_tap), "R10", "tap held", tap_o, exp_tap);
  endtask

  task automatic t_reset;
    chk(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
    chk(tap_o == 0 && maxlen_o == 0 && !err_o, "R1", "results after reset",
        {err_o, maxlen_o, tap_o}, 0);
  endtask

  task automatic t_ignore_start;
    int cyc = 0;
    int bc  = 0;
    @(negedge clk);
    start_i = 1'b1;
    map_i   = 64'h5555_5555_5555_5555;
    @(negedge clk);
    start_i = 1'b0;
    map_i   = '0;
    while (!done_o && cyc < 500) begin
      if (busy_o) bc++;
      if (cyc == 5) begin
        start_i = 1'b1;
        map_i   = '1;
      end else begin
        start_i = 1'b0;
        map_i   = '0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o, "R9", "done seen", done_o, 1);
    chk(tap_o == 0, "R9", "tap of first map", tap_o, 0);
    chk(maxlen_o == 1, "R9", "maxlen of first map", maxlen_o, 1);
    chk(bc == 64, "R9", "busy cycles of first map", bc, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // R2: empty map
    run_case("R2", 64'h0, 0, 0, 1'b1, 0);
    // R5: full map anchored at 0, single evaluation
    run_case("R5", '1, 21, 64, 1'b0, 1);
    // R3/R4: equal runs at both ends, no wrap, earliest kept
    run_case("R3", 64'hE000_0000_0000_0007, 1, 3, 1'b0, 60);
    // R4/R6: equal runs away from 0, midpoint of the lower one
    run_case("R4", 64'h0000_FF00_0003_FC00, 14, 8, 1'b0, -1);
    // R6: long upper window after a hole
    run_case("R6", 64'hFFFF_FFFF_FFFC_07FF, 41, 46, 1'b0, -1);
    // R8: alternating map, one position per cycle
    run_case("R8", 64'h5555_5555_5555_5555, 0, 1, 1'b0, 64);
    // R7: early stop on a 12-wide window at 0 despite a longer one above
    run_case("R7", 64'h0000_0000_7FFF_CFFF, 4, 12, 1'b0, 1);
    // R7: same lower half, bit 63 set, full scan
    run_case("R7", 64'h8000_0000_7FFF_CFFF, 22, 17, 1'b0, 37);
    // R7: early stop with best start at 2
    run_case("R7", 64'h0000_0000_FFFF_3FFC, 8, 12, 1'b0, 3);
    // R7: best start at 4 blocks early stop
    run_case("R7", 64'h0000_0000_FFFC_FFF0, 25, 14, 1'b0, -1);
    // R9: start during a scan ignored
    t_ignore_start();
    // R10: result follows the next accepted search
    run_case("R10", '1, 21, 64, 1'b0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule